// File: doc/BRIEF.md
# Thread Instruction Prefetch Buffer

This block keeps a short queue of prefetched instruction halfwords for a single hardware thread and presents the next complete instruction to the decoder. Instructions are either 16 bits (short) or 32 bits (long). A long instruction is recognised by the code in the top bits of its first halfword. The queue holds four halfwords, which is 64 bits. Refills come from a 32-bit memory read port. That port may only be used in cycles where the scheduler marks the thread's slot as free of data loads and stores. Memory returns the addressed word in the same cycle. Within a word, the lower halfword sits at the lower address.

A taken branch discards the queue and moves the fetch address to the word holding the target. When the target is the upper half of that word, the lower half of the first returned word is dropped. A small control FSM tracks this with two states. ST_RUN stores both halves of each fetched word. ST_SKIP_LO stores only the upper half of the next fetched word. The FSM has three transitions. Reset enters ST_SKIP_LO when the reset address is odd in bit 1, and ST_RUN otherwise. A redirect enters ST_SKIP_LO or ST_RUN by bit 1 of the target. An accepted refill moves to ST_RUN.

Top module: `ifetch_buf`

## Requirements
- R1: After reset the queue is empty, `ins_valid` is 0, and both `mem_addr` and `ins_pc` equal the reset address (0 by default).
- R2: `mem_req` is 1 exactly when `slot_free` is 1 and at most two halfwords are queued, meaning at least 32 bits are free.
- R3: `mem_addr` is word aligned. It advances by 4 after every cycle in which `mem_req` is 1 and no redirect is applied.
- R4: A halfword whose bits [15:11] equal 5'b11110 is a prefix. A long instruction is issued with `ins_long`=1 and `ins_data` = {prefix halfword, next halfword}. A short one is issued with `ins_long`=0 and `ins_data` = {16'h0, halfword}.
- R5: `ins_valid` is 1 only when the head instruction is complete. A prefix halfword queued alone gives `ins_valid`=0.
- R6: Each accepted instruction (`ins_valid` and `ins_ready`, no redirect) advances `ins_pc` by 2 for a short instruction and by 4 for a long one.
- R7: `redirect_valid` empties the queue, so `ins_valid` is 0 in the next cycle. The fetch address becomes the target with bits [1:0] cleared, and any handshake in that cycle is ignored.
- R8: When bit 1 of the target is set, the lower halfword of the first fetched word is discarded. The first instruction issued then has `ins_pc` equal to the target.
- R9: Under any pattern of slot grants, decoder stalls and redirects, the issued instructions match a sequential walk through memory from the last target.
- R10: The queue never holds more than four halfwords. With four halfwords queued, no refill is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_free | input | 1 | Thread's memory slot this cycle is not used by a load or store |
| mem_req | output | 1 | Refill read issued this cycle |
| mem_addr | output | AW | Word address of the refill |
| mem_rdata | input | 32 | Word returned in the same cycle |
| redirect_valid | input | 1 | Taken branch |
| redirect_pc | input | AW | Halfword-aligned branch target |
| ins_ready | input | 1 | Decoder accepts the presented instruction |
| ins_valid | output | 1 | A complete instruction is presented |
| ins_data | output | 32 | Instruction bits; short ones are zero-extended |
| ins_long | output | 1 | Presented instruction is 32 bits |
| ins_pc | output | AW | Address of the presented instruction |

## Verification
A wrong occupancy count shows up in the cycle it arises. `mem_req` is either raised with three queued halfwords or held low with two, and `ins_valid` disagrees with the model when a lone prefix sits at the head. A misaligned shift or append shows up at the next accepted instruction as a wrong `ins_data` or `ins_long`. A wrong PC step or a skipped lower halfword after an odd target shows up at the first issue after the fault, as an `ins_pc` mismatch. The model tracks occupancy, fetch address and walk position and compares them on every clock, so each of these faults is reported within a cycle of its first visible effect.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    localparam int HW_BITS  = 16;
    localparam int PFX_BITS = 5;
    localparam logic [PFX_BITS-1:0] PFX_CODE = 5'b11110;

    typedef enum logic {ST_RUN, ST_SKIP_LO} fstate_t;

    function automatic logic is_prefix(input logic [HW_BITS-1:0] hw);
        return hw[HW_BITS-1 -: PFX_BITS] == PFX_CODE;
    endfunction
endpackage

// File: rtl/ifb_queue.sv
module ifb_queue #(
    parameter int HW = 16,
    parameter int SLOTS = 4,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [1:0]      pop_n,
    input  logic            push_en,
    input  logic            push_lo,
    input  logic [2*HW-1:0] push_word,
    output logic [HW-1:0]   head0,
    output logic [HW-1:0]   head1,
    output logic [CW-1:0]   level
);
    logic [HW-1:0] slots_q [SLOTS];
    logic [HW-1:0] slots_d [SLOTS];
    logic [CW-1:0] level_q;
    int            after;
    int            lvl_n;

    always_comb begin
        after = int'(level_q) - int'(pop_n);
        lvl_n = after;
        for (int i = 0; i < SLOTS; i++) begin
            slots_d[i] = '0;
            for (int j = 0; j < SLOTS; j++) begin
                if (j == i + int'(pop_n)) slots_d[i] = slots_q[j];
            end
            if (push_en) begin
                if (push_lo) begin
                    if (i == after)     slots_d[i] = push_word[HW-1:0];
                    if (i == after + 1) slots_d[i] = push_word[2*HW-1:HW];
                end else if (i == after) begin
                    slots_d[i] = push_word[2*HW-1:HW];
                end
            end
        end
        if (push_en) lvl_n = after + (push_lo ? 2 : 1);
        if (flush)   lvl_n = 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            for (int i = 0; i < SLOTS; i++) slots_q[i] <= '0;
        end else begin
            level_q <= CW'(lvl_n);
            for (int i = 0; i < SLOTS; i++) slots_q[i] <= slots_d[i];
        end
    end

    assign head0 = slots_q[0];
    assign head1 = slots_q[1];
    assign level = level_q;

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CW'(SLOTS));

    assert_pop_within_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, pop_n} <= 3'(level_q));
endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
    import ifb_pkg::*;
#(
    parameter int AW = 16,
    parameter int SLOTS = 4,
    parameter logic [AW-1:0] RESET_PC = '0,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_free,
    input  logic [CW-1:0] level,
    input  logic          redirect_valid,
    input  logic [AW-1:1] redirect_hw,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          push_en,
    output logic          push_lo
);
    fstate_t       state_q, state_d;
    logic [AW-1:0] faddr_q, faddr_d;

    always_comb begin
        state_d = state_q;
        faddr_d = faddr_q;
        if (redirect_valid) begin
            state_d = redirect_hw[1] ? ST_SKIP_LO : ST_RUN;
            faddr_d = {redirect_hw[AW-1:2], 2'b00};
        end else if (mem_req) begin
            unique case (state_q)
                ST_RUN:     state_d = ST_RUN;
                ST_SKIP_LO: state_d = ST_RUN;
                default:    state_d = ST_RUN;
            endcase
            faddr_d = faddr_q + AW'(4);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_PC[1] ? ST_SKIP_LO : ST_RUN;
            faddr_q <= {RESET_PC[AW-1:2], 2'b00};
        end else begin
            state_q <= state_d;
            faddr_q <= faddr_d;
        end
    end

    always_comb begin
        mem_req  = slot_free && (level <= CW'(SLOTS - 2));
        mem_addr = faddr_q;
        push_en  = mem_req && !redirect_valid;
        unique case (state_q)
            ST_RUN:     push_lo = 1'b1;
            ST_SKIP_LO: push_lo = 1'b0;
            default:    push_lo = 1'b1;
        endcase
    end

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !redirect_valid) |=> (mem_addr == $past(mem_addr) + AW'(4)));
endmodule

// File: rtl/ifb_issue.sv
module ifb_issue
    import ifb_pkg::*;
#(
    parameter int AW = 16,
    parameter int SLOTS = 4,
    parameter logic [AW-1:0] RESET_PC = '0,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HW_BITS-1:0] head0,
    input  logic [HW_BITS-1:0] head1,
    input  logic [CW-1:0]      level,
    input  logic               ins_ready,
    input  logic               redirect_valid,
    input  logic [AW-1:0]      redirect_pc,
    output logic               ins_valid,
    output logic [31:0]        ins_data,
    output logic               ins_long,
    output logic [AW-1:0]      ins_pc,
    output logic [1:0]         pop_n
);
    logic          accept;
    logic [AW-1:0] pc_q;

    always_comb begin
        ins_long  = is_prefix(head0);
        ins_valid = (level >= CW'(1)) && (!ins_long || level >= CW'(2));
        ins_data  = ins_long ? {head0, head1} : {16'h0000, head0};
        accept    = ins_valid && ins_ready && !redirect_valid;
        pop_n     = accept ? (ins_long ? 2'd2 : 2'd1) : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              pc_q <= RESET_PC;
        else if (redirect_valid) pc_q <= redirect_pc;
        else if (accept)         pc_q <= pc_q + (ins_long ? AW'(4) : AW'(2));
    end

    assign ins_pc = pc_q;

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready && !redirect_valid)
        |=> (ins_pc == $past(ins_pc) + ($past(ins_long) ? AW'(4) : AW'(2))));
endmodule

// File: rtl/ifetch_buf.sv
module ifetch_buf #(
    parameter int AW = 16,
    parameter int SLOTS = 4,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_free,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    input  logic          redirect_valid,
    input  logic [AW-1:0] redirect_pc,
    input  logic          ins_ready,
    output logic          ins_valid,
    output logic [31:0]   ins_data,
    output logic          ins_long,
    output logic [AW-1:0] ins_pc
);
    localparam int CW = $clog2(SLOTS + 1);

    logic [CW-1:0] level;
    logic [15:0]   head0, head1;
    logic [1:0]    pop_n;
    logic          push_en, push_lo;

    ifb_queue #(.HW(16), .SLOTS(SLOTS)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(redirect_valid), .pop_n(pop_n),
        .push_en(push_en), .push_lo(push_lo), .push_word(mem_rdata),
        .head0(head0), .head1(head1), .level(level)
    );

    ifb_ctrl #(.AW(AW), .SLOTS(SLOTS), .RESET_PC(RESET_PC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_free(slot_free), .level(level),
        .redirect_valid(redirect_valid), .redirect_hw(redirect_pc[AW-1:1]),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .push_en(push_en), .push_lo(push_lo)
    );

    ifb_issue #(.AW(AW), .SLOTS(SLOTS), .RESET_PC(RESET_PC)) u_issue (
        .clk(clk), .rst_n(rst_n), .head0(head0), .head1(head1), .level(level),
        .ins_ready(ins_ready), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .ins_valid(ins_valid), .ins_data(ins_data),
        .ins_long(ins_long), .ins_pc(ins_pc), .pop_n(pop_n)
    );

    assert_redirect_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !ins_valid);

    assert_req_needs_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> slot_free);
endmodule

// File: tb/ifetch_buf_test.sv
module ifetch_buf_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        slot_free = 0, redirect_valid = 0, ins_ready = 0;
    logic [15:0] redirect_pc = '0;
    logic        mem_req, ins_valid, ins_long;
    logic [15:0] mem_addr, ins_pc;
    logic [31:0] mem_rdata, ins_data;

    logic [31:0] mem [1024];
    int checks = 0, errors = 0;
    bit done = 0;

    int          m_cnt = 0;
    logic [15:0] m_faddr = '0, r_pc = '0;
    bit          m_skip = 0, just_redir = 0;
    int          p_free = 50, p_ready = 70, p_redir = 3;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:2]];

    ifetch_buf uut (
        .clk(clk), .rst_n(rst_n), .slot_free(slot_free), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_data(ins_data),
        .ins_long(ins_long), .ins_pc(ins_pc)
    );

    function automatic logic [15:0] hw_at(input logic [15:0] a);
        logic [31:0] w = mem[a[11:2]];
        return a[1] ? w[31:16] : w[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step_model();
        bit          exp_req, exp_valid, pf, acc;
        logic [15:0] h0, h1;
        int          len;
        exp_req = slot_free && (m_cnt <= 2);
        h0 = hw_at(r_pc);
        h1 = hw_at(r_pc + 16'd2);
        pf = (h0[15:11] == 5'b11110);
        exp_valid = (m_cnt >= 1) && (!pf || m_cnt >= 2);
        chk(mem_req == exp_req, "R2 mem_req", 32'(mem_req), 32'(exp_req));
        chk(mem_addr == m_faddr && mem_addr[1:0] == 2'b00, "R3 mem_addr", 32'(mem_addr), 32'(m_faddr));
        chk(ins_valid == exp_valid, "R5 ins_valid", 32'(ins_valid), 32'(exp_valid));
        if (pf && m_cnt == 1)
            chk(!ins_valid, "R5 lone prefix", 32'(ins_valid), 32'd0);
        if (just_redir)
            chk(!ins_valid, "R7 empty after redirect", 32'(ins_valid), 32'd0);
        if (m_cnt == 4)
            chk(!mem_req, "R10 full no refill", 32'(mem_req), 32'd0);
        if (ins_valid && exp_valid) begin
            chk(ins_pc == r_pc, "R6 R8 ins_pc", 32'(ins_pc), 32'(r_pc));
            chk(ins_long == pf, "R4 ins_long", 32'(ins_long), 32'(pf));
            chk(ins_data == (pf ? {h0, h1} : {16'h0, h0}), "R4 R9 ins_data",
                ins_data, pf ? {h0, h1} : {16'h0, h0});
        end
        acc = exp_valid && ins_ready && !redirect_valid;
        if (redirect_valid) begin
            r_pc = redirect_pc;
            m_cnt = 0;
            m_faddr = {redirect_pc[15:2], 2'b00};
            m_skip = redirect_pc[1];
            just_redir = 1;
        end else begin
            just_redir = 0;
            if (acc) begin
                len = pf ? 2 : 1;
                m_cnt -= len;
                r_pc += 16'(2 * len);
            end
            if (exp_req) begin
                m_cnt += m_skip ? 1 : 2;
                m_skip = 0;
                m_faddr += 16'd4;
            end
        end
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #2;
            slot_free      = ($urandom_range(99) < p_free);
            ins_ready      = ($urandom_range(99) < p_ready);
            redirect_valid = ($urandom_range(99) < p_redir);
            redirect_pc    = {4'h0, 11'($urandom), 1'b0};
            @(negedge clk);
            step_model();
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] w = $urandom;
            if ($urandom_range(3) == 0) w[15:11] = 5'b11110;
            if ($urandom_range(3) == 0) w[31:27] = 5'b11110;
            mem[i] = w;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1: reset state, nothing queued, addresses at zero
        chk(!ins_valid, "R1 ins_valid", 32'(ins_valid), 32'd0);
        chk(mem_addr == 16'h0, "R1 mem_addr", 32'(mem_addr), 32'd0);
        chk(ins_pc == 16'h0, "R1 ins_pc", 32'(ins_pc), 32'd0);
        chk(!mem_req, "R1 R2 no slot", 32'(mem_req), 32'd0);
        run(2000);
        p_free = 100; p_ready = 0; p_redir = 0;
        run(50);
        p_free = 20; p_ready = 90; p_redir = 10;
        run(3000);
        p_free = 100; p_ready = 100; p_redir = 2;
        run(3000);
        p_free = 60; p_ready = 50; p_redir = 5;
        run(3000);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule